// File: doc/BRIEF.md
# Seconds and Fraction Time Counter with Alarm

This block keeps wall-clock time as one wide binary count that advances on every pulse of a slow reference tick (nominally 32.768 kHz, presented as a single-cycle strobe in the system clock domain). The upper part of the count is whole seconds. The lower part is the sub-second fraction, so its width sets the number of ticks per second. A seconds alarm register is compared against the count, and a match raises a sticky alarm flag. That flag can drive an interrupt request.

Counting is gated by several conditions. The seconds word must have been written at least once since reset. The enable control must be high. The non-valid input and the external freeze input must both be low. The sticky overflow flag must be clear. The freeze input comes from a security monitor: when it stops the count, the stored time marks the moment of the event. Software loads the seconds, the fraction and the alarm through write strobes. It clears the two status flags by writing ones to their bit positions.

Top module: `secfrac_timer`

## Requirements
- R1: While counting is allowed, each tick pulse increments the combined value {seconds, fraction} by one. The fraction therefore carries into the seconds once every 2^FRAC_W ticks.
- R2: After reset, seconds, fraction and both flags are zero and the interrupt request is low. Tick pulses have no effect until the seconds word has been written.
- R3: A seconds write loads the seconds word and leaves the fraction unchanged. A fraction write loads the fraction and leaves the seconds unchanged. A tick in the same cycle as either write is dropped.
- R4: A tick at the all-ones count makes the value zero and sets the overflow flag. The value then holds while the flag stays set, and counting resumes once the flag is cleared.
- R5: No tick advances the count while the enable input is low, the non-valid input is high, or the freeze input is high. The value held is kept.
- R6: The alarm flag sets on the clock edge at which counting moves the seconds word onto the alarm value, so the fraction then reads zero. A seconds write that lands on the alarm value does not set it.
- R7: An alarm value of all ones never matches, and the alarm register resets to all ones.
- R8: The interrupt request is high exactly when the alarm flag is set and the interrupt enable input is high.
- R9: A clear strobe clears the alarm flag where clear-data bit 0 is one, and the overflow flag where bit 1 is one. A flag whose bit is zero keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe of the reference tick |
| cnt_en_i | input | 1 | Counter enable control bit |
| nonvalid_i | input | 1 | Non-valid condition; stops counting while high |
| freeze_i | input | 1 | Freeze from the security monitor; stops counting while high |
| irq_en_i | input | 1 | Alarm interrupt enable |
| sec_we_i | input | 1 | Seconds write strobe |
| sec_wdata_i | input | SEC_W | Seconds write data |
| frac_we_i | input | 1 | Fraction write strobe |
| frac_wdata_i | input | FRAC_W | Fraction write data |
| alarm_we_i | input | 1 | Alarm write strobe |
| alarm_wdata_i | input | SEC_W | Alarm seconds write data |
| clr_we_i | input | 1 | Write-one-to-clear status strobe |
| clr_data_i | input | 2 | Clear mask: bit 0 alarm flag, bit 1 overflow flag |
| sec_o | output | SEC_W | Seconds readback |
| frac_o | output | FRAC_W | Fraction readback |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Alarm interrupt request |

## Verification
The properties assume that every write strobe and the tick are synchronous single-cycle pulses in the system clock domain. They also assume that the freeze, non-valid and enable levels change only between edges, not mid-cycle. The bench drives every input on the falling edge, so each pulse lasts exactly one rising edge. It uses a narrow configuration (4-bit seconds, 2-bit fraction), so the whole 64-state range can be swept through wrap-around, and every reachable alarm value is tried. Expected values come from tick counts alone.

// File: rtl/secfrac_pkg.sv
package secfrac_pkg;
   // status bit positions, shared by the clear mask and the flag bank
   localparam int unsigned ST_ALARM = 0;
   localparam int unsigned ST_OVF   = 1;
   localparam int unsigned ST_W     = 2;
endpackage

// File: rtl/secfrac_count.sv
module secfrac_count #(
   parameter int unsigned SEC_W  = 32,
   parameter int unsigned FRAC_W = 15
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              gate_ok_i,
   input  logic              ovf_i,
   input  logic              sec_we_i,
   input  logic [SEC_W-1:0]  sec_wd_i,
   input  logic              frac_we_i,
   input  logic [FRAC_W-1:0] frac_wd_i,
   output logic [SEC_W-1:0]  sec_o,
   output logic [FRAC_W-1:0] frac_o,
   output logic [SEC_W-1:0]  next_sec_o,
   output logic              sec_step_o,
   output logic              wrap_o
);
   localparam int unsigned CNT_W = SEC_W + FRAC_W;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   cnt_inc;
   logic             armed_q;
   logic             loading;
   logic             advance;

   assign loading = sec_we_i | frac_we_i;
   assign advance = tick_i & armed_q & gate_ok_i & ~ovf_i & ~loading;
   assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         if (sec_we_i) begin
            cnt_q[CNT_W-1:FRAC_W] <= sec_wd_i;
            armed_q               <= 1'b1;
         end
         if (frac_we_i) begin
            cnt_q[FRAC_W-1:0] <= frac_wd_i;
         end
         if (advance) begin
            cnt_q <= cnt_inc[CNT_W-1:0];
         end
      end
   end

   assign sec_o      = cnt_q[CNT_W-1:FRAC_W];
   assign frac_o     = cnt_q[FRAC_W-1:0];
   assign next_sec_o = cnt_inc[CNT_W-1:FRAC_W];
   assign sec_step_o = advance & (&cnt_q[FRAC_W-1:0]);
   assign wrap_o     = advance & cnt_inc[CNT_W];
endmodule

// File: rtl/secfrac_alarm.sv
module secfrac_alarm #(
   parameter int unsigned SEC_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             alarm_we_i,
   input  logic [SEC_W-1:0] alarm_wd_i,
   input  logic             sec_step_i,
   input  logic [SEC_W-1:0] next_sec_i,
   output logic             match_o
);
   logic [SEC_W-1:0] alarm_q;
   logic             unset;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         alarm_q <= '1;
      end else if (alarm_we_i) begin
         alarm_q <= alarm_wd_i;
      end
   end

   // all ones is the "no alarm" value
   assign unset   = &alarm_q;
   assign match_o = sec_step_i & ~unset & (next_sec_i == alarm_q);
endmodule

// File: rtl/secfrac_flag.sv
module secfrac_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         flag_o <= 1'b0;
      end else if (set_i) begin
         flag_o <= 1'b1;
      end else if (clr_i) begin
         flag_o <= 1'b0;
      end
   end
endmodule

// File: rtl/secfrac_timer.sv
module secfrac_timer
   import secfrac_pkg::*;
#(
   parameter int unsigned SEC_W   = 32,
   parameter int unsigned FRAC_W  = 15,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              cnt_en_i,
   input  logic              nonvalid_i,
   input  logic              freeze_i,
   input  logic              irq_en_i,
   input  logic              sec_we_i,
   input  logic [SEC_W-1:0]  sec_wdata_i,
   input  logic              frac_we_i,
   input  logic [FRAC_W-1:0] frac_wdata_i,
   input  logic              alarm_we_i,
   input  logic [SEC_W-1:0]  alarm_wdata_i,
   input  logic              clr_we_i,
   input  logic [ST_W-1:0]   clr_data_i,
   output logic [SEC_W-1:0]  sec_o,
   output logic [FRAC_W-1:0] frac_o,
   output logic              alarm_flag_o,
   output logic              ovf_flag_o,
   output logic              irq_o
);
   generate
      if (SEC_W < 2 || FRAC_W < 1 || SEC_W + FRAC_W > 64) begin : g_bad_cfg
         $error("secfrac_timer: SEC_W must be >= 2, FRAC_W >= 1, total <= 64");
      end
   endgenerate

   logic [SEC_W-1:0] next_sec;
   logic             sec_step;
   logic             wrap;
   logic             match;
   logic             gate_ok;
   logic [ST_W-1:0]  set_vec;
   logic [ST_W-1:0]  clr_vec;
   logic [ST_W-1:0]  flags;

   assign gate_ok = cnt_en_i & ~nonvalid_i & ~freeze_i;

   secfrac_count #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_count (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .gate_ok_i  (gate_ok),
      .ovf_i      (flags[ST_OVF]),
      .sec_we_i   (sec_we_i),
      .sec_wd_i   (sec_wdata_i),
      .frac_we_i  (frac_we_i),
      .frac_wd_i  (frac_wdata_i),
      .sec_o      (sec_o),
      .frac_o     (frac_o),
      .next_sec_o (next_sec),
      .sec_step_o (sec_step),
      .wrap_o     (wrap)
   );

   secfrac_alarm #(.SEC_W(SEC_W)) u_alarm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .alarm_we_i (alarm_we_i),
      .alarm_wd_i (alarm_wdata_i),
      .sec_step_i (sec_step),
      .next_sec_i (next_sec),
      .match_o    (match)
   );

   always_comb begin
      set_vec           = '0;
      set_vec[ST_ALARM] = match;
      set_vec[ST_OVF]   = wrap;
   end
   assign clr_vec = {ST_W{clr_we_i}} & clr_data_i;

   for (genvar i = 0; i < ST_W; i++) begin : g_flag
      secfrac_flag u_flag (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .set_i  (set_vec[i]),
         .clr_i  (clr_vec[i]),
         .flag_o (flags[i])
      );
   end

   assign alarm_flag_o = flags[ST_ALARM];
   assign ovf_flag_o   = flags[ST_OVF];

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) irq_q <= 1'b0;
            else         irq_q <= flags[ST_ALARM] & irq_en_i;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = flags[ST_ALARM] & irq_en_i;
      end
   endgenerate
endmodule

// File: rtl/secfrac_timer_chk.sv
module secfrac_timer_chk
   import secfrac_pkg::*;
#(
   parameter int unsigned SEC_W   = 32,
   parameter int unsigned FRAC_W  = 15,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              freeze_i,
   input logic              irq_en_i,
   input logic              sec_we_i,
   input logic              frac_we_i,
   input logic              clr_we_i,
   input logic [ST_W-1:0]   clr_data_i,
   input logic [SEC_W-1:0]  sec_o,
   input logic [FRAC_W-1:0] frac_o,
   input logic              alarm_flag_o,
   input logic              ovf_flag_o,
   input logic              irq_o
);
   // R5: a freeze with no load in the same cycle keeps the count
   assert_freeze_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (freeze_i && !sec_we_i && !frac_we_i) |=> ($stable(sec_o) && $stable(frac_o)));

   // R4: overflow flag is sticky until its clear bit is written
   assert_ovf_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_flag_o && !(clr_we_i && clr_data_i[ST_OVF])) |=> ovf_flag_o);

   // R1: seconds only move by counting when the fraction was all ones
   assert_sec_carry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sec_we_i && !frac_we_i && (frac_o != {FRAC_W{1'b1}})) |=> $stable(sec_o));

   // R6: a new alarm event lands on a whole second
   assert_alarm_whole_sec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(alarm_flag_o) |-> (frac_o == '0));

   // R9: alarm flag is sticky until its clear bit is written
   assert_alarm_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alarm_flag_o && !(clr_we_i && clr_data_i[ST_ALARM])) |=> alarm_flag_o);

   generate
      if (IRQ_REG) begin : g_chk_reg
         // R8: registered request follows flag and enable one cycle later
         assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o |-> $past(alarm_flag_o && irq_en_i));
      end else begin : g_chk_comb
         // R8: request only with flag and enable both present
         assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o |-> (alarm_flag_o && irq_en_i));
      end
   endgenerate
endmodule

bind secfrac_timer secfrac_timer_chk #(
   .SEC_W   (SEC_W),
   .FRAC_W  (FRAC_W),
   .IRQ_REG (IRQ_REG)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .freeze_i     (freeze_i),
   .irq_en_i     (irq_en_i),
   .sec_we_i     (sec_we_i),
   .frac_we_i    (frac_we_i),
   .clr_we_i     (clr_we_i),
   .clr_data_i   (clr_data_i),
   .sec_o        (sec_o),
   .frac_o       (frac_o),
   .alarm_flag_o (alarm_flag_o),
   .ovf_flag_o   (ovf_flag_o),
   .irq_o        (irq_o)
);

// File: tb/secfrac_timer_tb.sv
`timescale 1ns/1ps
module secfrac_timer_tb;
   localparam int unsigned SW = 4;
   localparam int unsigned FW = 2;
   localparam int unsigned NSTATE = 1 << (SW + FW);
   localparam int unsigned TPS = 1 << FW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          tick, cnt_en, nonvalid, freeze, irq_en;
   logic          sec_we, frac_we, alarm_we, clr_we;
   logic [SW-1:0] sec_wd, alarm_wd;
   logic [FW-1:0] frac_wd;
   logic [1:0]    clr_d;
   logic [SW-1:0] sec;
   logic [FW-1:0] frac;
   logic          alarm_flag, ovf_flag, irq;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   secfrac_timer #(.SEC_W(SW), .FRAC_W(FW), .IRQ_REG(1'b0)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cnt_en_i(cnt_en),
      .nonvalid_i(nonvalid), .freeze_i(freeze), .irq_en_i(irq_en),
      .sec_we_i(sec_we), .sec_wdata_i(sec_wd),
      .frac_we_i(frac_we), .frac_wdata_i(frac_wd),
      .alarm_we_i(alarm_we), .alarm_wdata_i(alarm_wd),
      .clr_we_i(clr_we), .clr_data_i(clr_d),
      .sec_o(sec), .frac_o(frac), .alarm_flag_o(alarm_flag),
      .ovf_flag_o(ovf_flag), .irq_o(irq)
   );

   function automatic int cnt_now();
      return int'({sec, frac});
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_tick();
      tick = 1'b1; @(negedge clk); tick = 1'b0;
   endtask
   task automatic wr_sec(input int v);
      sec_we = 1'b1; sec_wd = SW'(v); @(negedge clk); sec_we = 1'b0;
   endtask
   task automatic wr_frac(input int v);
      frac_we = 1'b1; frac_wd = FW'(v); @(negedge clk); frac_we = 1'b0;
   endtask
   task automatic wr_alarm(input int v);
      alarm_we = 1'b1; alarm_wd = SW'(v); @(negedge clk); alarm_we = 1'b0;
   endtask
   task automatic clr(input logic [1:0] m);
      clr_we = 1'b1; clr_d = m; @(negedge clk); clr_we = 1'b0; clr_d = '0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; tick = 0; cnt_en = 0; nonvalid = 0; freeze = 0; irq_en = 0;
      sec_we = 0; frac_we = 0; alarm_we = 0; clr_we = 0;
      sec_wd = '0; frac_wd = '0; alarm_wd = '0; clr_d = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: reset state
      chk(cnt_now() == 0, "R2 reset count", cnt_now(), 0);
      chk(alarm_flag == 0 && ovf_flag == 0, "R2 reset flags", {alarm_flag, ovf_flag}, 0);
      chk(irq == 0, "R2 reset irq", irq, 0);

      // R2: ticks before any seconds write do nothing
      cnt_en = 1'b1;
      repeat (5) do_tick();
      chk(cnt_now() == 0, "R2 unarmed", cnt_now(), 0);

      // R1 / R7: full sweep with reset alarm value (all ones) never matching
      wr_sec(0);
      for (int i = 1; i < NSTATE; i++) begin
         do_tick();
         chk(cnt_now() == i, "R1 sweep", cnt_now(), i);
         chk(alarm_flag == 0, "R7 reset alarm unset", alarm_flag, 0);
      end

      // R4: wrap
      do_tick();
      chk(cnt_now() == 0, "R4 wrap value", cnt_now(), 0);
      chk(ovf_flag == 1, "R4 ovf set", ovf_flag, 1);
      repeat (3) do_tick();
      chk(cnt_now() == 0, "R4 hold", cnt_now(), 0);

      // R9: clear with only the alarm bit leaves overflow
      clr(2'b01);
      chk(ovf_flag == 1, "R9 ovf kept", ovf_flag, 1);
      clr(2'b10);
      chk(ovf_flag == 0, "R9 ovf cleared", ovf_flag, 0);
      do_tick();
      chk(cnt_now() == 1, "R4 resume", cnt_now(), 1);

      // R5: gating conditions
      cnt_en = 1'b0; repeat (3) do_tick();
      chk(cnt_now() == 1, "R5 enable low", cnt_now(), 1);
      cnt_en = 1'b1; nonvalid = 1'b1; repeat (3) do_tick();
      chk(cnt_now() == 1, "R5 nonvalid", cnt_now(), 1);
      nonvalid = 1'b0; freeze = 1'b1; repeat (3) do_tick();
      chk(cnt_now() == 1, "R5 freeze", cnt_now(), 1);
      freeze = 1'b0; do_tick();
      chk(cnt_now() == 2, "R5 released", cnt_now(), 2);

      // R3: loads and load-over-tick precedence
      wr_frac(3);
      chk(cnt_now() == 3, "R3 frac load", cnt_now(), 3);
      wr_sec(9);
      chk(cnt_now() == 9 * TPS + 3, "R3 sec load", cnt_now(), 9 * TPS + 3);
      sec_we = 1'b1; sec_wd = SW'(2); tick = 1'b1;
      @(negedge clk);
      sec_we = 1'b0; tick = 1'b0;
      chk(cnt_now() == 2 * TPS + 3, "R3 load beats tick", cnt_now(), 2 * TPS + 3);
      frac_we = 1'b1; frac_wd = FW'(1); tick = 1'b1;
      @(negedge clk);
      frac_we = 1'b0; tick = 1'b0;
      chk(cnt_now() == 2 * TPS + 1, "R3 frac beats tick", cnt_now(), 2 * TPS + 1);

      // R6 / R8 / R9: every usable alarm value
      for (int a = 1; a < (1 << SW) - 1; a++) begin
         irq_en = 1'b0;
         wr_alarm(a);
         wr_frac(0);
         wr_sec(a);
         chk(alarm_flag == 0, "R6 write no match", alarm_flag, 0);
         wr_sec(0);
         clr(2'b11);
         for (int k = 1; k <= a * TPS; k++) begin
            do_tick();
            if (k < a * TPS)
               chk(alarm_flag == 0, "R6 early", alarm_flag, 0);
         end
         chk(alarm_flag == 1, "R6 match", alarm_flag, 1);
         chk(int'(sec) == a && frac == 0, "R6 match time", cnt_now(), a * TPS);
         chk(irq == 0, "R8 masked", irq, 0);
         irq_en = 1'b1; #1;
         chk(irq == 1, "R8 enabled", irq, 1);
         do_tick();
         chk(alarm_flag == 1, "R9 sticky", alarm_flag, 1);
         clr(2'b10);
         chk(alarm_flag == 1, "R9 alarm kept", alarm_flag, 1);
         clr(2'b01);
         chk(alarm_flag == 0, "R9 alarm cleared", alarm_flag, 0);
         chk(irq == 0, "R8 cleared", irq, 0);
      end

      // R7: explicit all-ones alarm
      irq_en = 1'b0;
      wr_alarm((1 << SW) - 1);
      wr_frac(0);
      wr_sec((1 << SW) - 2);
      repeat (TPS) do_tick();
      chk(int'(sec) == (1 << SW) - 1, "R7 reached all ones", sec, (1 << SW) - 1);
      chk(alarm_flag == 0, "R7 no match", alarm_flag, 0);

      finish_run();
   end
endmodule